// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that behaves like a small byte-wide serial EEPROM. A parameter sets the storage to 128 or 256 bytes. SCL and SDA are oversampled with the system clock. SDA is driven only through an open-drain pull-down enable, and a logic high comes from releasing the line. A write-protect input and a synchronous reset are the only other controls. The reset stands in for power-on reset.

A master selects the target with a select byte. It then writes single bytes or pages of up to 16 bytes, or reads from the current address, from a given address, or sequentially for as long as it keeps acknowledging. Written bytes are collected in a page staging buffer. After the STOP, an internal write cycle of a parameterized number of clocks runs, and the array changes only at its end. During that cycle the target refuses its select byte, so a master can poll with select bytes until one is acknowledged.

Top module: `eep_top`

## Requirements
- R1: After reset the SDA pull-down is released and the address pointer is 0, so a current-address read returns the byte at address 0. Reset does not clear the array.
- R2: The select byte is 1010 in bits 7:4, `ce_i` in bits 3:1, and R/W in bit 0 (1 = read). Only a matching select byte is acknowledged. On a mismatch the target stays silent until the next START.
- R3: A byte write (select/write, address, data, STOP) stores the data byte at the address once the internal write cycle ends. Each accepted data byte is acknowledged.
- R4: A write sends up to 16 bytes into one page. The low 4 address bits wrap within that page. When more than 16 bytes are sent, later bytes overwrite earlier ones.
- R5: A random read returns the byte at the address given in a dummy write, followed by a repeated START and a read select byte.
- R6: A current-address read uses the pointer. After a write the pointer is the last written address plus one, wrapped inside the page. After each byte read it advances by one.
- R7: A sequential read continues while the master acknowledges. It crosses page boundaries and wraps from the last address to address 0.
- R8: After a data byte the target releases SDA for the 9th clock. If the master does not acknowledge, the target drives nothing more until a START or STOP.
- R9: While `wc_i` is 1, select and address bytes are still acknowledged, but data bytes are not acknowledged. No write cycle starts and the array is unchanged.
- R10: Reads return the same data whatever the level of `wc_i`.
- R11: For `WRITE_CYCLES` clocks after a write's STOP, plus the page commit, the select byte is not acknowledged. Afterwards it is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset (power-on reset stand-in) |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| ce_i | input | 3 | Chip-enable bits compared with select byte bits 3:1 |
| wc_i | input | 1 | Write protect, 1 blocks all writes |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
Several properties are checked on every cycle. SDA is released whenever the target is idle and right after any START or STOP. A select byte seen during the write cycle never gets an acknowledge, and a data byte under write protect never gets one either. An array write never happens in the first cycle of a write cycle. Only the bench's bus scenarios can show the data behaviours: stored values after byte and page writes, in-page wrap and overwrite, pointer continuity for current and sequential reads across pages and the end of the array, the release after a master NACK, and that the polling window closes after the write cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int PAGE_AW = 4;
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_t;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_ADDR,
    BY_DATA
  } byte_kind_t;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic scl_q;
  logic sda_q;
  logic scl_s;
  logic sda_s;

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_lvl   = sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle import eep_pkg::*; #(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      buf_clr,
  input  logic                      buf_we,
  input  logic [PAGE_AW-1:0]        buf_idx,
  input  logic [7:0]                buf_data,
  input  logic                      page_ld,
  input  logic [ADDR_W-PAGE_AW-1:0] page_in,
  input  logic                      kick,
  output logic                      busy,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_waddr,
  output logic [7:0]                mem_wdata
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [7:0]                pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]     pvalid;
  logic [ADDR_W-PAGE_AW-1:0] page_q;
  logic [CW-1:0]             tmr;
  logic                      timing;
  logic                      committing;
  logic [PAGE_AW-1:0]        cidx;

  assign busy = timing | committing | mem_we;

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pvalid     <= '0;
      timing     <= 1'b0;
      committing <= 1'b0;
      tmr        <= '0;
      cidx       <= '0;
      mem_we     <= 1'b0;
      page_q     <= '0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
    end else begin
      mem_we <= 1'b0;
      if (buf_clr) pvalid <= '0;
      else if (buf_we) pvalid[buf_idx] <= 1'b1;
      if (page_ld) page_q <= page_in;
      if (kick && !busy) begin
        timing <= 1'b1;
        tmr    <= '0;
      end else if (timing) begin
        if (tmr == CW'(WRITE_CYCLES - 1)) begin
          timing     <= 1'b0;
          committing <= 1'b1;
          cidx       <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else if (committing) begin
        mem_we    <= pvalid[cidx];
        mem_waddr <= {page_q, cidx};
        mem_wdata <= pbuf[cidx];
        cidx      <= cidx + 1'b1;
        if (cidx == PAGE_AW'(PAGE_BYTES - 1)) committing <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eep_top.sv
module eep_top import eep_pkg::*; #(
  parameter int MEM_BYTES    = 256,
  parameter int WRITE_CYCLES = 250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] ce_i,
  input  logic       wc_i,
  output logic       sda_oe_o
);
  localparam int ADDR_W = $clog2(MEM_BYTES);

  logic scl_rise, scl_fall, bus_start, bus_stop, sda_lvl;
  bus_st_t            st;
  byte_kind_t         kind;
  logic [3:0]         cnt;
  logic [7:0]         sr;
  logic [6:0]         txsr;
  logic [ADDR_W-1:0]  ptr;
  logic               go_read;
  logic               mack;
  logic               wr_pend;
  logic               busy;
  logic [7:0]         rdata;
  logic               buf_clr, buf_we, page_ld, kick;
  logic [PAGE_AW-1:0] buf_idx;
  logic [7:0]         buf_data;
  logic               mem_we;
  logic [ADDR_W-1:0]  mem_waddr;
  logic [7:0]         mem_wdata;

  eep_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(bus_start), .stop_det(bus_stop), .sda_lvl(sda_lvl)
  );

  eep_store #(.DEPTH(MEM_BYTES), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rdata)
  );

  eep_wcycle #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_wcyc (
    .clk(clk), .rst(rst),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .page_ld(page_ld), .page_in(ptr[ADDR_W-1:PAGE_AW]), .kick(kick),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind     <= BY_DEV;
      cnt      <= '0;
      sr       <= '0;
      txsr     <= '0;
      ptr      <= '0;
      go_read  <= 1'b0;
      mack     <= 1'b0;
      wr_pend  <= 1'b0;
      sda_oe_o <= 1'b0;
      buf_clr  <= 1'b0;
      buf_we   <= 1'b0;
      page_ld  <= 1'b0;
      kick     <= 1'b0;
      buf_idx  <= '0;
      buf_data <= '0;
    end else begin
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      page_ld <= 1'b0;
      kick    <= 1'b0;
      if (bus_stop) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
        kick     <= wr_pend;
        wr_pend  <= 1'b0;
      end else if (bus_start) begin
        st       <= ST_RX;
        kind     <= BY_DEV;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
        wr_pend  <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sr  <= {sr[6:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                BY_DEV: begin
                  if (sr[7:1] == {DEV_TYPE, ce_i} && !busy) begin
                    sda_oe_o <= 1'b1;
                    st       <= ST_RX_ACK;
                    go_read  <= sr[0];
                    buf_clr  <= ~sr[0];
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                BY_ADDR: begin
                  ptr      <= sr[ADDR_W-1:0];
                  page_ld  <= 1'b1;
                  sda_oe_o <= 1'b1;
                  st       <= ST_RX_ACK;
                end
                BY_DATA: begin
                  if (wc_i) begin
                    wr_pend <= 1'b0;
                    st      <= ST_IDLE;
                  end else begin
                    buf_we            <= 1'b1;
                    buf_idx           <= ptr[PAGE_AW-1:0];
                    buf_data          <= sr;
                    ptr[PAGE_AW-1:0]  <= ptr[PAGE_AW-1:0] + 1'b1;
                    wr_pend           <= 1'b1;
                    sda_oe_o          <= 1'b1;
                    st                <= ST_RX_ACK;
                  end
                end
                default: st <= ST_IDLE;
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (kind == BY_DEV && go_read) begin
                txsr     <= rdata[6:0];
                sda_oe_o <= ~rdata[7];
                ptr      <= ptr + 1'b1;
                cnt      <= '0;
                st       <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_RX;
                kind     <= (kind == BY_DEV) ? BY_ADDR : BY_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                cnt      <= '0;
                mack     <= 1'b0;
                st       <= ST_TX_ACK;
              end else begin
                sda_oe_o <= ~txsr[6];
                txsr     <= {txsr[5:0], 1'b0};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                txsr     <= rdata[6:0];
                sda_oe_o <= ~rdata[7];
                ptr      <= ptr + 1'b1;
                cnt      <= '0;
                st       <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_chk.sv
module eep_chk import eep_pkg::*; (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       busy,
  input logic       mem_we,
  input logic       bus_start,
  input logic       bus_stop,
  input bus_st_t    st,
  input byte_kind_t kind,
  input logic [3:0] cnt,
  input logic       scl_fall,
  input logic       wc
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> !sda_oe); // R8

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
    bus_start && !bus_stop |=> !sda_oe); // R1

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !sda_oe); // R8

  AST_BUSY_NO_SELECT_ACK: assert property (@(posedge clk) disable iff (rst)
    st == ST_RX && kind == BY_DEV && cnt == 4'd8 && scl_fall && busy |=> !sda_oe); // R11

  AST_PROTECT_NO_DATA_ACK: assert property (@(posedge clk) disable iff (rst)
    st == ST_RX && kind == BY_DATA && cnt == 4'd8 && scl_fall && wc |=> !sda_oe); // R9

  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !mem_we); // R3
endmodule

bind eep_top eep_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .busy(busy), .mem_we(mem_we),
  .bus_start(bus_start), .bus_stop(bus_stop), .st(st), .kind(kind),
  .cnt(cnt), .scl_fall(scl_fall), .wc(wc_i)
);

// File: tb/tb_eep_top.sv
module tb_eep_top;
  localparam int WCYC = 300;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic wc = 1'b0;
  logic [2:0] ce = 3'b101;
  logic sda_oe;
  wire  sda_line = msda & ~sda_oe;

  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 8'h00;

  always #10 clk = ~clk;

  eep_top #(.MEM_BYTES(256), .WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .ce_i(ce), .wc_i(wc), .sda_oe_o(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic s);
    tick(Q); msda = b;
    tick(Q); scl = 1'b1;
    tick(Q); s = sda_line;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_start();
    msda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    msda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    msda = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s);
    bit_io(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      d = {d[6:0], s};
    end
    bit_io(~ack, s);
  endtask

  task automatic poll(input logic exp_ack, input string req);
    logic a;
    bus_start();
    send_byte(SEL_W, a);
    check(req, a, exp_ack);
    bus_stop();
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] q[$], input string req);
    logic a;
    bus_start();
    send_byte(SEL_W, a); check({req, " select ack"}, a, 1);
    send_byte(addr, a);  check({req, " address ack"}, a, 1);
    ref_ptr = addr;
    foreach (q[j]) begin
      send_byte(q[j], a);
      check({req, " data ack"}, a, wc ? 0 : 1);
      if (wc) break;
      ref_mem[{addr[7:4], 4'(addr[3:0] + j)}] = q[j];
    end
    if (!wc) ref_ptr = {addr[7:4], 4'(addr[3:0] + q.size())};
    bus_stop();
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(req, d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string req);
    logic a;
    bus_start();
    send_byte(SEL_W, a); check({req, " select ack"}, a, 1);
    send_byte(addr, a);  check({req, " address ack"}, a, 1);
    ref_ptr = addr;
    bus_start();
    send_byte(SEL_R, a); check({req, " read select ack"}, a, 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string req);
    logic a;
    bus_start();
    send_byte(SEL_R, a); check({req, " read select ack"}, a, 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  task automatic wait_wcycle();
    tick(WCYC + 80);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] q[$];
    logic a, s, quiet;
    logic [7:0] d;
    tick(5);
    rst = 1'b0;
    tick(5);
    // R1: released after reset
    check("R1 sda released after reset", sda_oe, 0);

    // R3: byte write, then R11 polling
    q = {8'hA5};
    do_write(8'h10, q, "R3 byte write");
    poll(1'b0, "R11 select refused during write cycle");
    wait_wcycle();
    poll(1'b1, "R11 select accepted after write cycle");
    rand_read(8'h10, 1, "R5 random read of byte write");

    // R4: full pages at 0x00, 0x20, 0xF0
    q = {};
    for (int i = 0; i < 16; i++) q.push_back(8'(8'h30 + i));
    do_write(8'h00, q, "R4 page write 0x00"); wait_wcycle();
    q = {};
    for (int i = 0; i < 16; i++) q.push_back(8'(8'h60 + 3 * i));
    do_write(8'h20, q, "R4 page write 0x20"); wait_wcycle();
    // R6: pointer after full page wraps to page start
    cur_read(1, "R6 current read after page write");
    q = {};
    for (int i = 0; i < 16; i++) q.push_back(8'(8'hC0 ^ i));
    do_write(8'hF0, q, "R4 page write 0xF0"); wait_wcycle();

    // R4: wrap inside the page
    q = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    do_write(8'h2C, q, "R4 in-page wrap write"); wait_wcycle();
    cur_read(2, "R6 current read after wrapped write");
    rand_read(8'h20, 16, "R4 page contents after wrap");

    // R4: 17 bytes, last overwrites first slot
    q = {};
    for (int i = 0; i < 17; i++) q.push_back(8'(8'h80 + i));
    do_write(8'h40, q, "R4 overfull page write"); wait_wcycle();
    rand_read(8'h40, 16, "R4 overwrite of first slot");

    // R7: sequential read across array end
    rand_read(8'hF8, 16, "R7 sequential read wrapping to 0");
    cur_read(3, "R6 current read continues after sequential read");

    // R8: after master NACK the target stays silent
    rand_read(8'h05, 1, "R8 read ended with NACK");
    bus_start();
    send_byte(SEL_R, a);
    check("R8 read select ack", a, 1);
    recv_byte(1'b0, d);
    check("R8 byte before NACK", d, ref_mem[ref_ptr]);
    ref_ptr = ref_ptr + 8'd1;
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, s);
      if (!s) quiet = 1'b0;
    end
    check("R8 line released after NACK", quiet, 1);
    bus_stop();

    // R2: wrong chip-enable bits
    bus_start();
    send_byte(8'hA4, a);
    check("R2 mismatched select not acked", a, 0);
    send_byte(8'h00, a);
    check("R2 following byte ignored", a, 0);
    bus_stop();
    ce = 3'b010;
    bus_start();
    send_byte(8'hA4, a);
    check("R2 select acked with matching ce", a, 1);
    bus_stop();
    ce = 3'b101;

    // R9, R10: write protect
    wc = 1'b1;
    q = {8'h3C};
    do_write(8'h10, q, "R9 protected write");
    poll(1'b1, "R9 no write cycle after protected write");
    rand_read(8'h10, 1, "R10 read under protect");
    cur_read(1, "R10 current read under protect");
    wc = 1'b0;
    rand_read(8'h10, 1, "R9 array unchanged after protect");

    // R1: pointer back to 0 after reset, array kept
    tick(10);
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(5);
    check("R1 sda released after second reset", sda_oe, 0);
    ref_ptr = 8'h00;
    cur_read(2, "R1 current read from 0 after reset");

    finish_run();
  end
endmodule